// File: doc/BRIEF.md
# CPU Space Cycle Decoder

This block sits beside the processor bus and examines every cycle whose function code marks it as CPU space. It sorts each such cycle into one of several kinds: breakpoint acknowledge, interrupt acknowledge, low-power-stop broadcast, an access to the module base register, a reserved slot inside the internal window, or some other CPU-space cycle. Cycles in the fixed 256-byte internal window are claimed and finished inside the chip. For interrupt acknowledges the block checks the acknowledged level against the live request lines. If that level is set for autovectoring, it starts an external acknowledge, finishes it internally and supplies the vector number. If the request has already gone away, it rejects the acknowledge as spurious.

The block also decodes the 4 KiB internal register block from a programmable base address. A mask control keeps CPU-space cycles out of that decode, so that acknowledge addresses near the top of memory cannot collide with the register block. Every decision is taken at the first clock edge that samples the strobe high, and it holds until the strobe falls.

Top module: `cpusp_decoder`

## Requirements
- R1: The decode is taken at the first rising edge at which `strobe_i` is high while the block is idle, and `kind_o` holds it until an edge samples `strobe_i` low. The encoding is: 0 when `fc_i` is not 7; otherwise, from `addr_i[19:16]`, 1 for 0x0 (breakpoint acknowledge) and 2 for 0xF (interrupt acknowledge). When `addr_i[19:8]` is 0x3FF the code is 4, 3 or 5, as R3, R4 and R5 give. Every other CPU-space cycle is 6.
- R2: Every cycle in the internal window (codes 3, 4 and 5) pulses `term_o` for exactly one cycle. The pulse is registered at the second rising edge that samples `strobe_i` high.
- R3: Offsets 0x00 to 0x03 of the window select the base register (code 4). Such an access never raises `ext_ack_o` or `blk_hit_o`.
- R4: Offset 0xFE of the window is the low-power-stop broadcast (code 3).
- R5: Offsets 0x04 to 0xFD and offset 0xFF select nothing (code 5), and the cycle is still terminated.
- R6: A breakpoint acknowledge reports `addr_i[4:2]` on `brk_num_o` and `addr_i[1]` on `brk_t_o`. It is not terminated internally. Both outputs are 0 for every other kind.
- R7: An interrupt acknowledge reports `addr_i[3:1]` on `level_o`. When level L (1 to 7) has `irq_i[L-1]` and `autovec_i[L-1]` both set, `ext_ack_o` pulses for one cycle after the first edge. `term_o` then follows as in R2, with `vector_o` equal to 24+L.
- R8: An interrupt acknowledge at level 0, or at a level whose `irq_i` bit is low at the deciding edge, is terminated as in R2 with `spurious_o` high and `vector_o` equal to 24. No `ext_ack_o` is raised.
- R9: An interrupt acknowledge whose level is requested but not autovectored gets no `term_o`, no `ext_ack_o` and no `spurious_o`.
- R10: `blk_hit_o` is high when `base_en_i` is set and `addr_i[31:12]` equals `base_addr_i`. It is forced low for CPU-space cycles while `cpu_mask_i` is set, and for window cycles.
- R11: After reset, and whenever idle, every output is 0. Outside a terminating cycle, `vector_o` and `spurious_o` are 0.
- R12: If `strobe_i` falls before the second edge, the cycle is dropped with no `term_o`, and the outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | synchronous reset, active low |
| fc_i | input | 3 | function code of the current cycle |
| addr_i | input | 32 | cycle address |
| strobe_i | input | 1 | address strobe, active high |
| base_addr_i | input | 20 | register block base, address bits 31:12 |
| base_en_i | input | 1 | register block decode enable |
| cpu_mask_i | input | 1 | keep CPU-space cycles out of the block decode |
| irq_i | input | 7 | live interrupt requests, bit L-1 is level L |
| autovec_i | input | 7 | autovector enables, bit L-1 is level L |
| kind_o | output | 3 | cycle kind code (R1) |
| brk_num_o | output | 3 | breakpoint number |
| brk_t_o | output | 1 | breakpoint T bit |
| level_o | output | 3 | acknowledged interrupt level |
| blk_hit_o | output | 1 | internal register block selected |
| ext_ack_o | output | 1 | external autovector acknowledge started |
| term_o | output | 1 | internal termination pulse |
| vector_o | output | 8 | vector number, valid with term_o |
| spurious_o | output | 1 | spurious acknowledge, valid with term_o |

## Verification
The assertions assume that `fc_i`, `addr_i`, the base controls and the request lines stay stable while `strobe_i` is high. They also assume that `strobe_i` is low for at least one edge between cycles. The bench changes inputs only while the strobe is low. It drops the strobe after every cycle, and it cuts some cycles short only by lowering the strobe, never by changing the address. Random cycles are weighted toward the window, acknowledges and base-address matches, so that the rare kinds occur often.

// File: rtl/cpusp_pkg.sv
// Shared types and constants for the CPU space cycle decoder.
// Assumes CPU space is function code 7 and cycle type sits in address bits 19:16.
package cpusp_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_BKPT    = 3'd1,
        K_IACK    = 3'd2,
        K_LPSTOP  = 3'd3,
        K_BASEREG = 3'd4,
        K_RSVD    = 3'd5,
        K_OTHER   = 3'd6
    } kind_e;

    localparam logic [2:0] FC_CPU      = 3'd7;
    localparam logic [3:0] TYPE_BKPT   = 4'h0;
    localparam logic [3:0] TYPE_IACK   = 4'hF;
    localparam logic [3:0] TYPE_WIN    = 4'h3;
    localparam logic [7:0] WIN_PAGE    = 8'hFF;
    localparam logic [7:0] LPSTOP_OFS  = 8'hFE;
    localparam logic [7:0] BASEREG_END = 8'h03;

    // Window kinds are terminated by the block itself.
    function automatic logic is_window(input kind_e k);
        return (k == K_LPSTOP) || (k == K_BASEREG) || (k == K_RSVD);
    endfunction

endpackage

// File: rtl/cpusp_classify.sv
// Combinational sort of a bus cycle into a kind, plus breakpoint and level fields.
// Assumes address and function code are stable while the strobe is high.
module cpusp_classify
    import cpusp_pkg::*;
(
    input  logic [2:0]  fc_i,
    input  logic [19:0] addr_lo_i,
    output kind_e       kind_o,
    output logic [2:0]  brk_num_o,
    output logic        brk_t_o,
    output logic [2:0]  level_o
);

    logic [3:0] cyc_type;
    logic [7:0] page;
    logic [7:0] ofs;

    assign cyc_type = addr_lo_i[19:16];
    assign page     = addr_lo_i[15:8];
    assign ofs      = addr_lo_i[7:0];

    // Kind selection, first by CPU space, then type, then window offset.
    always_comb begin
        kind_o = K_NONE;
        if (fc_i == FC_CPU) begin
            if (cyc_type == TYPE_BKPT) begin
                kind_o = K_BKPT;
            end else if (cyc_type == TYPE_IACK) begin
                kind_o = K_IACK;
            end else if (cyc_type == TYPE_WIN && page == WIN_PAGE) begin
                if (ofs <= BASEREG_END)      kind_o = K_BASEREG;
                else if (ofs == LPSTOP_OFS)  kind_o = K_LPSTOP;
                else                         kind_o = K_RSVD;
            end else begin
                kind_o = K_OTHER;
            end
        end
    end

    // Field extraction, zero unless the kind owns the field.
    always_comb begin
        brk_num_o = (kind_o == K_BKPT) ? addr_lo_i[4:2] : 3'd0;
        brk_t_o   = (kind_o == K_BKPT) ? addr_lo_i[1]   : 1'b0;
        level_o   = (kind_o == K_IACK) ? addr_lo_i[3:1] : 3'd0;
    end

endmodule

// File: rtl/cpusp_iack.sv
// Resolves an interrupt acknowledge against live requests and autovector enables.
// Assumes request lines are level sensitive and sampled at the deciding edge.
module cpusp_iack #(
    parameter int LEVELS   = 7,
    parameter int VEC_BASE = 24,
    localparam int LVL_W   = $clog2(LEVELS + 1)
) (
    input  logic              iack_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [LEVELS-1:0] irq_i,
    input  logic [LEVELS-1:0] autovec_i,
    output logic              auto_o,
    output logic              spur_o,
    output logic [7:0]        vector_o
);

    logic [LEVELS-1:0] lvl_sel;
    logic              pend;
    logic              av;

    // One select line per nonzero level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign lvl_sel[g] = (level_i == LVL_W'(g + 1));
    end

    // Pending and autovector lookups; level 0 selects nothing.
    always_comb begin
        pend = |(lvl_sel & irq_i);
        av   = |(lvl_sel & autovec_i);
    end

    // Outcome and vector number.
    always_comb begin
        auto_o   = iack_i && pend && av;
        spur_o   = iack_i && !pend;
        vector_o = 8'd0;
        if (spur_o)      vector_o = 8'(VEC_BASE);
        else if (auto_o) vector_o = 8'(VEC_BASE) + 8'(level_i);
    end

endmodule

// File: rtl/cpusp_blkdec.sv
// Decodes the internal register block from the programmable base.
// Assumes the block is 2**BLK_BITS bytes and aligned to its size.
module cpusp_blkdec #(
    parameter int ADDR_W   = 32,
    parameter int BLK_BITS = 12,
    localparam int HI_W    = ADDR_W - BLK_BITS
) (
    input  logic [HI_W-1:0] addr_hi_i,
    input  logic [HI_W-1:0] base_hi_i,
    input  logic            base_en_i,
    input  logic            cpu_space_i,
    input  logic            cpu_mask_i,
    input  logic            window_i,
    output logic            hit_o
);

    // Match unless masked for CPU space or taken by the window.
    always_comb begin
        hit_o = base_en_i && (addr_hi_i == base_hi_i)
                && !(cpu_space_i && cpu_mask_i) && !window_i;
    end

endmodule

// File: rtl/cpusp_seq.sv
// Cycle sequencer: detects a new strobe, counts to the termination edge.
// Assumes the strobe is low for at least one edge between cycles; TERM_DLY >= 2.
module cpusp_seq #(
    parameter int TERM_DLY = 2,
    localparam int CNT_W   = $clog2(TERM_DLY + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic claim_i,
    output logic start_o,
    output logic clear_o,
    output logic term_o
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} seq_e;

    seq_e             state;
    logic [CNT_W-1:0] cnt;

    assign start_o = (state == S_IDLE) && strobe_i;
    assign clear_o = (state != S_IDLE) && !strobe_i;

    // State, edge counter and registered termination pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state  <= S_IDLE;
            cnt    <= '0;
            term_o <= 1'b0;
        end else begin
            term_o <= 1'b0;
            case (state)
                S_IDLE: if (strobe_i) begin
                    state <= S_RUN;
                    cnt   <= CNT_W'(1);
                end
                S_RUN: if (!strobe_i) begin
                    state <= S_IDLE;
                end else if (cnt == CNT_W'(TERM_DLY - 1)) begin
                    term_o <= claim_i;
                    state  <= S_HOLD;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                default: if (!strobe_i) state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cpusp_decoder.sv
// Top of the CPU space cycle decoder: classifies, latches the decision at the
// first strobe edge, and issues internal termination, vector and spurious flag.
// Assumes inputs stay stable while the strobe is high.
module cpusp_decoder
    import cpusp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BLK_BITS = 12,
    parameter int LEVELS   = 7,
    parameter int VEC_BASE = 24,
    parameter int TERM_DLY = 2,
    localparam int HI_W    = ADDR_W - BLK_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        fc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_i,
    input  logic [HI_W-1:0]   base_addr_i,
    input  logic              base_en_i,
    input  logic              cpu_mask_i,
    input  logic [LEVELS-1:0] irq_i,
    input  logic [LEVELS-1:0] autovec_i,
    output logic [2:0]        kind_o,
    output logic [2:0]        brk_num_o,
    output logic              brk_t_o,
    output logic [2:0]        level_o,
    output logic              blk_hit_o,
    output logic              ext_ack_o,
    output logic              term_o,
    output logic [7:0]        vector_o,
    output logic              spurious_o
);

    kind_e      kind_c;
    logic [2:0] brk_c, lvl_c;
    logic       brkt_c, hit_c, auto_c, spur_c, win_c, claim_c;
    logic [7:0] vec_c;
    logic       start, clear, term_q, claim_q, spur_q;
    logic [7:0] vec_q;

    cpusp_classify u_cls (
        .fc_i      (fc_i),
        .addr_lo_i (addr_i[19:0]),
        .kind_o    (kind_c),
        .brk_num_o (brk_c),
        .brk_t_o   (brkt_c),
        .level_o   (lvl_c)
    );

    cpusp_iack #(.LEVELS(LEVELS), .VEC_BASE(VEC_BASE)) u_iack (
        .iack_i    (kind_c == K_IACK),
        .level_i   (lvl_c),
        .irq_i     (irq_i),
        .autovec_i (autovec_i),
        .auto_o    (auto_c),
        .spur_o    (spur_c),
        .vector_o  (vec_c)
    );

    assign win_c   = is_window(kind_c);
    assign claim_c = win_c || auto_c || spur_c;

    cpusp_blkdec #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_blk (
        .addr_hi_i   (addr_i[ADDR_W-1:BLK_BITS]),
        .base_hi_i   (base_addr_i),
        .base_en_i   (base_en_i),
        .cpu_space_i (fc_i == FC_CPU),
        .cpu_mask_i  (cpu_mask_i),
        .window_i    (win_c),
        .hit_o       (hit_c)
    );

    cpusp_seq #(.TERM_DLY(TERM_DLY)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe_i),
        .claim_i  (claim_q),
        .start_o  (start),
        .clear_o  (clear),
        .term_o   (term_q)
    );

    // Latch the decision at the start edge; clear it when the strobe drops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear) begin
            kind_o    <= K_NONE;
            brk_num_o <= '0;
            brk_t_o   <= 1'b0;
            level_o   <= '0;
            blk_hit_o <= 1'b0;
            claim_q   <= 1'b0;
            spur_q    <= 1'b0;
            vec_q     <= '0;
        end else if (start) begin
            kind_o    <= kind_c;
            brk_num_o <= brk_c;
            brk_t_o   <= brkt_c;
            level_o   <= lvl_c;
            blk_hit_o <= hit_c;
            claim_q   <= claim_c;
            spur_q    <= spur_c;
            vec_q     <= vec_c;
        end
    end

    // One-cycle external acknowledge for autovectored levels.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ext_ack_o <= 1'b0;
        else         ext_ack_o <= start && auto_c;
    end

    // Vector and spurious flag are presented only with the termination pulse.
    always_comb begin
        term_o     = term_q;
        vector_o   = term_q ? vec_q : 8'd0;
        spurious_o = term_q && spur_q;
    end

endmodule

// File: rtl/cpusp_decoder_chk.sv
// Property checker for cpusp_decoder, bound to every instance.
// Assumes inputs are stable while the strobe is high.
module cpusp_decoder_chk #(
    parameter int VEC_BASE = 24
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       strobe_i,
    input logic       cpu_mask_i,
    input logic [2:0] kind_o,
    input logic       blk_hit_o,
    input logic       ext_ack_o,
    input logic       term_o,
    input logic [7:0] vector_o,
    input logic       spurious_o
);

    // R2
    term_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |=> !term_o);

    // R12
    term_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |-> $past(strobe_i));

    // R8
    spur_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spurious_o |-> (term_o && vector_o == 8'(VEC_BASE) && kind_o == 3'd2));

    // R7
    ext_then_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_ack_o && strobe_i) |=> (term_o && !spurious_o && vector_o > 8'(VEC_BASE)));

    // R6
    bkpt_noterm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |-> (kind_o != 3'd1));

    // R3
    basereg_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_o == 3'd4) |-> (!ext_ack_o && !blk_hit_o));

    // R10
    mask_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_hit_o && cpu_mask_i) |-> (kind_o == 3'd0));

    // R11
    vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !term_o |-> (vector_o == 8'd0 && !spurious_o));

endmodule

bind cpusp_decoder cpusp_decoder_chk #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .cpu_mask_i (cpu_mask_i),
    .kind_o     (kind_o),
    .blk_hit_o  (blk_hit_o),
    .ext_ack_o  (ext_ack_o),
    .term_o     (term_o),
    .vector_o   (vector_o),
    .spurious_o (spurious_o)
);

// File: tb/cpusp_decoder_test.sv
// Bench for cpusp_decoder: directed corners plus seeded random cycles.
module cpusp_decoder_test;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  fc_i = '0;
    logic [31:0] addr_i = '0;
    logic        strobe_i = 1'b0;
    logic [19:0] base_addr_i = '0;
    logic        base_en_i = 1'b0;
    logic        cpu_mask_i = 1'b0;
    logic [6:0]  irq_i = '0;
    logic [6:0]  autovec_i = '0;
    logic [2:0]  kind_o, brk_num_o, level_o;
    logic        brk_t_o, blk_hit_o, ext_ack_o, term_o, spurious_o;
    logic [7:0]  vector_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cpusp_decoder uut (.*);

    always #10 clk_i = ~clk_i;

    // Expected-value model, written from the requirements.
    typedef struct {
        logic [2:0] kind, brk, lvl;
        logic bt, hit, ext, term, spur;
        logic [7:0] vec;
    } exp_t;

    function automatic exp_t model(input logic [2:0] fc, input logic [31:0] a,
                                   input logic [19:0] bh, input logic ben, input logic msk,
                                   input logic [6:0] irq, input logic [6:0] av);
        exp_t e;
        logic pend, au, win;
        e = '{kind: 3'd0, brk: 3'd0, lvl: 3'd0, bt: 1'b0, hit: 1'b0,
              ext: 1'b0, term: 1'b0, spur: 1'b0, vec: 8'd0};
        if (fc == 3'd7) begin
            if (a[19:16] == 4'h0)      e.kind = 3'd1;
            else if (a[19:16] == 4'hF) e.kind = 3'd2;
            else if (a[19:8] == 12'h3FF) begin
                if (a[7:0] <= 8'h03)      e.kind = 3'd4;
                else if (a[7:0] == 8'hFE) e.kind = 3'd3;
                else                      e.kind = 3'd5;
            end else e.kind = 3'd6;
        end
        win = (e.kind == 3'd3) || (e.kind == 3'd4) || (e.kind == 3'd5);
        if (e.kind == 3'd1) begin e.brk = a[4:2]; e.bt = a[1]; end
        if (e.kind == 3'd2) e.lvl = a[3:1];
        e.hit = ben && (a[31:12] == bh) && !(fc == 3'd7 && msk) && !win;
        pend = (e.lvl != 0) && irq[e.lvl - 1];
        au   = (e.kind == 3'd2) && pend && av[e.lvl - 1];
        e.spur = (e.kind == 3'd2) && !pend;
        e.ext  = au;
        e.term = win || au || e.spur;
        e.vec  = e.spur ? 8'd24 : (au ? 8'd24 + 8'(e.lvl) : 8'd0);
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One bus cycle; hold=0 drops the strobe after the first edge (R12).
    task automatic run_cycle(input logic [2:0] fc, input logic [31:0] a,
                             input logic [19:0] bh, input logic ben, input logic msk,
                             input logic [6:0] irq, input logic [6:0] av, input bit hold);
        exp_t e;
        e = model(fc, a, bh, ben, msk, irq, av);
        @(negedge clk_i);
        fc_i = fc; addr_i = a; base_addr_i = bh; base_en_i = ben;
        cpu_mask_i = msk; irq_i = irq; autovec_i = av; strobe_i = 1'b1;
        @(negedge clk_i);
        chk("R1", "kind", kind_o, e.kind);
        chk("R6", "brk_num", brk_num_o, e.brk);
        chk("R6", "brk_t", brk_t_o, e.bt);
        chk("R7", "level", level_o, e.lvl);
        chk("R10", "blk_hit", blk_hit_o, e.hit);
        chk("R7", "ext_ack", ext_ack_o, e.ext);
        chk("R2", "term early", term_o, 0);
        if (!hold) begin
            strobe_i = 1'b0;
            @(negedge clk_i);
            chk("R12", "term after drop", term_o, 0);
            chk("R12", "kind after drop", kind_o, 0);
            @(negedge clk_i);
            chk("R12", "term late", term_o, 0);
            return;
        end
        @(negedge clk_i);
        chk("R2", "term", term_o, e.term);
        chk("R8", "spurious", spurious_o, e.spur);
        chk("R7", "vector", vector_o, e.vec);
        chk("R7", "ext_ack gone", ext_ack_o, 0);
        @(negedge clk_i);
        chk("R2", "term single", term_o, 0);
        chk("R11", "vector off", vector_o, 0);
        chk("R1", "kind held", kind_o, e.kind);
        strobe_i = 1'b0;
        @(negedge clk_i);
        chk("R11", "idle kind", kind_o, 0);
        chk("R11", "idle hit", blk_hit_o, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0]  fc;
        logic [31:0] a;
        logic [19:0] bh;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk_i);
        // R11 reset state
        chk("R11", "reset kind", kind_o, 0);
        chk("R11", "reset term", term_o, 0);
        chk("R11", "reset vector", vector_o, 0);
        chk("R11", "reset ext", ext_ack_o, 0);
        rst_ni = 1'b1;
        // R3 base register, also with matching block base
        run_cycle(3'd7, 32'h0003FF00, 20'h00003, 1'b1, 1'b0, 7'h00, 7'h00, 1'b1);
        run_cycle(3'd7, 32'h0003FF03, 20'h00000, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        // R4 low-power-stop broadcast
        run_cycle(3'd7, 32'h0003FFFE, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        // R5 reserved boundaries
        run_cycle(3'd7, 32'h0003FF04, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        run_cycle(3'd7, 32'h0003FFFD, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        run_cycle(3'd7, 32'h0003FFFF, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        // R6 breakpoint fields
        run_cycle(3'd7, 32'h0000001E, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        // R7 autovector level 7 at top-of-memory acknowledge address
        run_cycle(3'd7, 32'hFFFFFFFE, 20'hFFFFF, 1'b1, 1'b1, 7'h40, 7'h40, 1'b1);
        // R10 same cycle without the mask: block decode responds
        run_cycle(3'd7, 32'hFFFFFFFE, 20'hFFFFF, 1'b1, 1'b0, 7'h40, 7'h40, 1'b1);
        // R8 request withdrawn, and level 0
        run_cycle(3'd7, 32'hFFFFFFF6, 20'h0, 1'b0, 1'b0, 7'h7B, 7'h7F, 1'b1);
        run_cycle(3'd7, 32'hFFFFFFF0, 20'h0, 1'b0, 1'b0, 7'h7F, 7'h7F, 1'b1);
        // R9 requested but externally vectored
        run_cycle(3'd7, 32'hFFFFFFF4, 20'h0, 1'b0, 1'b0, 7'h02, 7'h00, 1'b1);
        // R10 normal space block hit
        run_cycle(3'd5, 32'h00ABC123, 20'h00ABC, 1'b1, 1'b1, 7'h00, 7'h00, 1'b1);
        // R12 early strobe drop on a window cycle
        run_cycle(3'd7, 32'h0003FFFE, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b0);
        // R1 other CPU space type
        run_cycle(3'd7, 32'h00020000, 20'h0, 1'b0, 1'b0, 7'h00, 7'h00, 1'b1);
        // Random cycles across all kinds (R1 to R12)
        for (int i = 0; i < 400; i++) begin
            fc = ($urandom_range(0, 3) != 0) ? 3'd7 : 3'($urandom_range(0, 6));
            a  = $urandom();
            case ($urandom_range(0, 4))
                0: a[19:8] = 12'h3FF;
                1: a[19:16] = 4'hF;
                2: a[19:16] = 4'h0;
                3: a[7:0] = ($urandom_range(0, 1) != 0) ? 8'hFE : 8'(a[1:0]);
                default: ;
            endcase
            if ($urandom_range(0, 4) == 0) a[19:8] = 12'h3FF;
            bh = ($urandom_range(0, 1) != 0) ? a[31:12] : 20'($urandom());
            run_cycle(fc, a, bh, 1'($urandom()), 1'($urandom()),
                      7'($urandom()), 7'($urandom()), $urandom_range(0, 7) != 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule